// File: doc/BRIEF.md
# SDRAM Bank Timing Guard

This block sits beside an SDRAM command path. It keeps track of four independent banks and decides, in the same cycle, whether the command presented on its input may legally be issued. Each command is a strobe with a command code, a bank address and the A10 flag. While the strobe is high, the block raises exactly one of two flags: accept or reject. It also reports, one bit per bank, whether a row is currently open in that bank.

Every timing limit is a parameter counted in clock cycles. The block checks the activate-to-activate spacing and the rolling limit of two activates in any row-cycle window. It also checks the activate-to-column delay, the minimum row-active time before a precharge, and the precharge recovery time. A read with A10 high carries an automatic precharge. That precharge starts a burst length after the read, and the bank stays locked until the precharge has finished. Only accepted commands change state. A rejected command changes nothing, so the caller can hold a command and retry it on a later cycle.

Top module: `sdram_bank_guard`

## Requirements
- R1: After reset, all bank_open bits are 0. An activate to any bank is accepted on the first cycle after reset is released.
- R2: Command codes are: activate 2'b00, read 2'b01, write 2'b10, precharge 2'b11. An activate to a closed bank is accepted, and that bank's bank_open bit rises on the next cycle. An activate to an open bank is rejected.
- R3: An activate issued fewer than T_RRD cycles after the previous accepted activate, to any bank, is rejected.
- R4: An activate is rejected when the accepted activate two before it lies fewer than T_RC cycles back.
- R5: A read or write is accepted only if its bank is open and at least T_RCD cycles have passed since that bank's activate. Otherwise it is rejected.
- R6: A precharge with A10 low closes only the addressed bank. It is rejected while fewer than T_RAS cycles have passed since that bank's activate.
- R7: A precharge with A10 low to a bank that is already closed is accepted and changes nothing.
- R8: A precharge with A10 high ignores the bank address and closes every open bank. It is rejected if any open bank has not yet met T_RAS, or if any bank still has an automatic precharge pending.
- R9: An activate to a bank is rejected until T_RP cycles have passed since that bank was precharged.
- R10: A read with A10 high that is issued at cycle t starts an automatic precharge. The bank's bank_open bit falls at cycle t+BURST. Every command to that bank is rejected until cycle t+BURST+T_RP, when an activate becomes legal. A write with A10 high is an ordinary write.
- R11: A rejected command changes no bank state and no timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_code | input | 2 | Command code (see R2) |
| cmd_bank | input | BA_W | Target bank address |
| cmd_a10 | input | 1 | Automatic precharge on read, all banks on precharge |
| cmd_accept | output | 1 | Command is legal and takes effect (combinational) |
| cmd_reject | output | 1 | Command is illegal and is ignored (combinational) |
| bank_open | output | NUM_BANKS | Per-bank row-open state |

## Verification
The assertions assume that every timing parameter is at least one cycle. They also assume that cmd_code, cmd_bank and cmd_a10 carry known values whenever cmd_valid is high. The automatic-precharge properties further assume that command codes other than read never set a bank into the pending-precharge state. The stimulus holds all inputs at defined values on every cycle, including cycles where cmd_valid is low. Random draws cover every code, bank and A10 value. Command types are weighted toward activates and precharges so that the timing windows are actually reached and crossed.

// File: rtl/sdram_guard_pkg.sv
// Shared types for the SDRAM bank timing guard.
// Assumes: command codes are fixed by the port contract (see brief R2).
package sdram_guard_pkg;

    typedef enum logic [1:0] {
        CMD_ACT   = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10,
        CMD_PRE   = 2'b11
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE    = 2'b00,
        BK_ACTIVE  = 2'b01,
        BK_AUTOPRE = 2'b10
    } bank_st_e;

    // Width of a down-counter that must hold the value maxv.
    function automatic int cnt_w(input int maxv);
        return (maxv < 2) ? 1 : $clog2(maxv + 1);
    endfunction

endpackage

// File: rtl/sdram_act_window.sv
// Activate spacing tracker, shared by all banks.
// It enforces the T_RRD gap after the last accepted activate. It also
// enforces the rolling window: no more than two activates in any T_RC cycles.
// Assumes: T_RRD >= 1 and T_RC >= 1, and act_fire pulses only for accepted activates.
module sdram_act_window
    import sdram_guard_pkg::*;
#(
    parameter int T_RRD = 2,
    parameter int T_RC  = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_fire,
    output logic act_ok
);
    localparam int RRD_W = cnt_w(T_RRD);
    localparam int RC_W  = cnt_w(T_RC);
    localparam int SMAX  = (T_RC > T_RRD) ? T_RC : T_RRD;
    localparam int S_W   = cnt_w(SMAX);

    logic [RRD_W-1:0] rrd_cnt;
    logic [RC_W-1:0]  age_last;
    logic [RC_W-1:0]  age_prev;

    // Count down the spacing timers, and reload them on an accepted activate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rrd_cnt  <= '0;
            age_last <= '0;
            age_prev <= '0;
        end else if (act_fire) begin
            rrd_cnt  <= RRD_W'(T_RRD - 1);
            age_prev <= (age_last != '0) ? age_last - 1'b1 : '0;
            age_last <= RC_W'(T_RC - 1);
        end else begin
            if (rrd_cnt != '0)  rrd_cnt  <= rrd_cnt - 1'b1;
            if (age_last != '0) age_last <= age_last - 1'b1;
            if (age_prev != '0) age_prev <= age_prev - 1'b1;
        end
    end

    // An activate is legal when both the gap and the window have expired.
    assign act_ok = (rrd_cnt == '0) && (age_prev == '0);

    // Checker state: cycles since the last two activates, saturating.
    logic [S_W-1:0] since_last;
    logic [S_W-1:0] since_prev;

    // Independent cycle counters that the properties below use.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_last <= S_W'(SMAX);
            since_prev <= S_W'(SMAX);
        end else if (act_fire) begin
            since_prev <= (since_last >= S_W'(SMAX)) ? S_W'(SMAX) : since_last + 1'b1;
            since_last <= S_W'(1);
        end else begin
            if (since_last < S_W'(SMAX)) since_last <= since_last + 1'b1;
            if (since_prev < S_W'(SMAX)) since_prev <= since_prev + 1'b1;
        end
    end

    assert_act_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        act_fire |-> since_last >= S_W'(T_RRD));

    assert_act_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        act_fire |-> since_prev >= S_W'(T_RC));

endmodule

// File: rtl/sdram_bank_tracker.sv
// State and timers for one SDRAM bank.
// It tracks three states: idle, row active, and automatic precharge pending.
// One recovery counter covers both the T_RP wait after an explicit precharge
// and the BURST+T_RP lock after a read with automatic precharge.
// Assumes: at most one do_* strobe per cycle, and each strobe only for an accepted command.
module sdram_bank_tracker
    import sdram_guard_pkg::*;
#(
    parameter int T_RCD = 3,
    parameter int T_RAS = 6,
    parameter int T_RP  = 3,
    parameter int BURST = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic do_act,
    input  logic do_autopre,
    input  logic do_pre,
    output logic can_act,
    output logic can_col,
    output logic can_pre,
    output logic is_open
);
    localparam int REC_MAX = BURST + T_RP;
    localparam int RCD_W   = cnt_w(T_RCD);
    localparam int RAS_W   = cnt_w(T_RAS);
    localparam int REC_W   = cnt_w(REC_MAX);

    bank_st_e         st;
    logic [RCD_W-1:0] rcd_cnt;
    logic [RAS_W-1:0] ras_cnt;
    logic [REC_W-1:0] rec_cnt;

    // Bank state transitions and timer reloads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= BK_IDLE;
            rcd_cnt <= '0;
            ras_cnt <= '0;
            rec_cnt <= '0;
        end else begin
            if (rcd_cnt != '0) rcd_cnt <= rcd_cnt - 1'b1;
            if (ras_cnt != '0) ras_cnt <= ras_cnt - 1'b1;
            if (rec_cnt != '0) rec_cnt <= rec_cnt - 1'b1;
            if (st == BK_AUTOPRE && rec_cnt == '0) st <= BK_IDLE;
            if (do_act) begin
                st      <= BK_ACTIVE;
                rcd_cnt <= RCD_W'(T_RCD - 1);
                ras_cnt <= RAS_W'(T_RAS - 1);
            end else if (do_autopre) begin
                st      <= BK_AUTOPRE;
                rec_cnt <= REC_W'(REC_MAX - 1);
            end else if (do_pre && st == BK_ACTIVE) begin
                st      <= BK_IDLE;
                rec_cnt <= REC_W'(T_RP - 1);
            end
        end
    end

    // Per-command legality for this bank.
    always_comb begin
        can_act = (st != BK_ACTIVE) && (rec_cnt == '0);
        can_col = (st == BK_ACTIVE) && (rcd_cnt == '0);
        if (st == BK_ACTIVE) can_pre = (ras_cnt == '0);
        else                 can_pre = (st == BK_IDLE) || (rec_cnt == '0);
        is_open = (st == BK_ACTIVE) || (st == BK_AUTOPRE && rec_cnt > REC_W'(T_RP));
    end

    assert_act_on_closed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        do_act |-> (st != BK_ACTIVE && !is_open));

    assert_pre_after_ras_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (do_pre && st == BK_ACTIVE) |-> ras_cnt == '0);

    assert_autopre_after_rcd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        do_autopre |-> (st == BK_ACTIVE && rcd_cnt == '0));

    assert_autopre_locks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        do_autopre |=> (!can_act && !can_col && !can_pre && is_open));

endmodule

// File: rtl/sdram_bank_guard.sv
// SDRAM bank timing guard (top).
// It decides in the same cycle whether the presented command is legal and
// raises cmd_accept or cmd_reject. Only accepted commands update the bank
// trackers and the activate window.
// Assumes: NUM_BANKS >= 2, and every timing parameter >= 1 cycle.
module sdram_bank_guard
    import sdram_guard_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int T_RRD     = 2,
    parameter int T_RCD     = 3,
    parameter int T_RAS     = 6,
    parameter int T_RP      = 3,
    parameter int T_RC      = 9,
    parameter int BURST     = 4,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_code,
    input  logic [BA_W-1:0]      cmd_bank,
    input  logic                 cmd_a10,
    output logic                 cmd_accept,
    output logic                 cmd_reject,
    output logic [NUM_BANKS-1:0] bank_open
);
    cmd_e                 op;
    logic                 legal;
    logic                 win_ok;
    logic                 act_fire;
    logic [NUM_BANKS-1:0] can_act, can_col, can_pre;
    logic [NUM_BANKS-1:0] do_act, do_autopre, do_pre;

    assign op = cmd_e'(cmd_code);

    // Legality of the presented command against bank and window state.
    always_comb begin
        case (op)
            CMD_ACT:   legal = win_ok && can_act[cmd_bank];
            CMD_READ,
            CMD_WRITE: legal = can_col[cmd_bank];
            CMD_PRE:   legal = cmd_a10 ? (&can_pre) : can_pre[cmd_bank];
            default:   legal = 1'b0;
        endcase
    end

    assign cmd_accept = cmd_valid && legal;
    assign cmd_reject = cmd_valid && !legal;
    assign act_fire   = cmd_accept && (op == CMD_ACT);

    sdram_act_window #(
        .T_RRD (T_RRD),
        .T_RC  (T_RC)
    ) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_fire (act_fire),
        .act_ok   (win_ok)
    );

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        logic hit;
        // Route the accepted command to the bank it targets.
        assign hit           = (cmd_bank == BA_W'(i));
        assign do_act[i]     = act_fire && hit;
        assign do_autopre[i] = cmd_accept && (op == CMD_READ) && cmd_a10 && hit;
        assign do_pre[i]     = cmd_accept && (op == CMD_PRE) && (cmd_a10 || hit);

        sdram_bank_tracker #(
            .T_RCD (T_RCD),
            .T_RAS (T_RAS),
            .T_RP  (T_RP),
            .BURST (BURST)
        ) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .do_act     (do_act[i]),
            .do_autopre (do_autopre[i]),
            .do_pre     (do_pre[i]),
            .can_act    (can_act[i]),
            .can_col    (can_col[i]),
            .can_pre    (can_pre[i]),
            .is_open    (bank_open[i])
        );
    end

    assert_all_close_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_accept && op == CMD_PRE && cmd_a10) |=> bank_open == '0);

    assert_reject_opens_none_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reject |=> ($countones(bank_open) <= $countones($past(bank_open))));

endmodule

// File: tb/sdram_bank_guard_test.sv
`timescale 1ns/1ps
module sdram_bank_guard_test;
    localparam int NB = 4, TRRD = 2, TRCD = 3, TRAS = 6, TRP = 3, TRC = 9, BL = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_code = 2'b00;
    logic [1:0]    cmd_bank = 2'b00;
    logic          cmd_a10 = 1'b0;
    logic          cmd_accept, cmd_reject;
    logic [NB-1:0] bank_open;

    sdram_bank_guard #(.NUM_BANKS(NB), .T_RRD(TRRD), .T_RCD(TRCD), .T_RAS(TRAS),
                       .T_RP(TRP), .T_RC(TRC), .BURST(BL)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_bank(cmd_bank), .cmd_a10(cmd_a10), .cmd_accept(cmd_accept),
        .cmd_reject(cmd_reject), .bank_open(bank_open));

    always #2.5 clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 1'b0;
    // Reference model: 0 idle, 1 active, 2 automatic precharge pending.
    int mst[NB], t_act[NB], t_pre[NB], t_ap[NB];
    int last_a = -1000, prev_a = -1000;

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    function automatic bit idle_now(int b);
        return mst[b] == 0 || (mst[b] == 2 && cyc >= t_ap[b] + BL + TRP);
    endfunction

    function automatic bit open_now(int b);
        return mst[b] == 1 || (mst[b] == 2 && cyc < t_ap[b] + BL);
    endfunction

    function automatic bit pre_ok(int b);
        if (mst[b] == 1) return (cyc - t_act[b]) >= TRAS;
        return idle_now(b);
    endfunction

    function automatic bit legal(int c, int b, bit a);
        case (c)
            0: return idle_now(b) && (cyc - t_pre[b] >= TRP) &&
                      (cyc - last_a >= TRRD) && (cyc - prev_a >= TRC);
            1, 2: return mst[b] == 1 && (cyc - t_act[b] >= TRCD);
            default: begin
                if (!a) return pre_ok(b);
                for (int k = 0; k < NB; k++) if (!pre_ok(k)) return 1'b0;
                return 1'b1;
            end
        endcase
    endfunction

    task automatic update(int c, int b, bit a);
        case (c)
            0: begin mst[b] = 1; t_act[b] = cyc; prev_a = last_a; last_a = cyc; end
            1: if (a) begin mst[b] = 2; t_ap[b] = cyc; end
            3: for (int k = 0; k < NB; k++)
                   if ((a || k == b) && mst[k] == 1) begin mst[k] = 0; t_pre[k] = cyc; end
            default: ;
        endcase
    endtask

    // One cycle: drive, check the outputs against the model, advance the model.
    task automatic step(bit v, int c, int b, bit a, string tag);
        logic [NB-1:0] eo;
        bit e;
        @(negedge clk);
        cmd_valid = v; cmd_code = 2'(c); cmd_bank = 2'(b); cmd_a10 = a;
        #1;
        for (int k = 0; k < NB; k++) eo[k] = open_now(k);
        check({tag, " bank_open"}, int'(bank_open), int'(eo));
        if (v) begin
            e = legal(c, b, a);
            check({tag, " verdict"}, int'({cmd_accept, cmd_reject}), int'({e, !e}));
            if (e) update(c, b, a);
        end
        cyc++;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b0, 0, 0, 1'b0, "R11");
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #500000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NB; k++) begin mst[k] = 0; t_act[k] = -1000; t_pre[k] = -1000; t_ap[k] = -1000; end
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Directed corner cases with default timing.
        step(1, 0, 0, 0, "R1");          // c0 ACT b0 accepted after reset
        step(1, 0, 1, 0, "R3");          // c1 ACT b1 too close
        step(1, 0, 1, 0, "R11");         // c2 accepted: c1 reject left gap timer alone
        step(1, 0, 2, 0, "R4");          // c3 third ACT inside window
        step(1, 1, 1, 0, "R5");          // c4 READ before tRCD
        step(1, 1, 1, 0, "R5");          // c5 READ ok
        step(1, 1, 3, 0, "R5");          // c6 READ closed bank
        step(1, 0, 0, 0, "R2");          // c7 ACT on open bank
        step(1, 3, 0, 0, "R6");          // c8 PRE b0 after tRAS
        step(1, 0, 2, 0, "R4");          // c9 window expired
        step(1, 0, 0, 0, "R9");          // c10 tRP pending
        step(1, 0, 0, 0, "R9");          // c11 ACT after tRP
        step(1, 3, 3, 0, "R7");          // c12 PRE idle bank no-op
        step(1, 3, 1, 1, "R8");          // c13 PREA blocked by tRAS
        idle(3);
        step(1, 3, 2, 1, "R8");          // c17 PREA closes all
        step(1, 0, 3, 0, "R8");          // c18 all closed, ACT b3
        idle(2);
        step(1, 1, 3, 1, "R10");         // c21 READ with auto-precharge
        step(1, 1, 3, 0, "R10");         // c22 locked
        step(1, 3, 3, 0, "R10");         // c23 locked
        idle(3);
        step(1, 0, 3, 0, "R10");         // c27 one cycle early
        step(1, 0, 3, 0, "R10");         // c28 ACT legal again
        idle(2);
        step(1, 2, 3, 1, "R10");         // WRITE with A10 is plain
        step(1, 1, 3, 0, "R10");         // bank still open
        // Constrained random traffic.
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom % 10;
            int c = (r < 4) ? 0 : (r < 6) ? 1 : (r < 7) ? 2 : 3;
            step(($urandom % 4) != 0, c, $urandom % NB, ($urandom % 4) == 0,
                 (c == 0) ? "R3" : (c == 3) ? "R6" : "R5");
        end
        done = 1'b1;
        summary();
        $finish;
    end
endmodule